// File: doc/BRIEF.md
# Error-Tagged Serial Receive Queue

This block turns an asynchronous serial line into a queue of received characters. A single oversampling tick drives the bit timing, at 16 or 8 ticks per bit. A state machine confirms each start bit at the middle of the bit and assembles 5 to 8 data bits, least significant first. It then checks an optional parity bit and one or two stop bits. Each finished character is written into a deep first-in first-out store as an 11-bit entry: the data byte and three flags for that character (parity error, framing error, break).

The host sees only the entry at the head of the queue, and the flags shown there always belong to that character. The host also sees how many characters are waiting and a ready indication. Ready is raised when the count reaches a programmable threshold, which may be set to any count. A one-cycle pop strobe removes the head entry. If a character completes while the queue is full, that character is dropped and an overrun flag is raised.

The receiver state machine has six states:
- IDLE waits for a low line level on a tick and then goes to START.
- START goes back to IDLE if the line reads high on any tick before mid-bit (glitch). It goes to DATA when mid-bit is reached with the line still low.
- DATA goes to PARITY after the last data bit when parity is on, and to STOP when it is off.
- PARITY goes to STOP after one bit.
- STOP goes to PUSH after the last stop bit.
- PUSH writes the entry and returns to IDLE in the next clock cycle.

The format inputs must be held steady while a character is being received.

Top module: `rx_tagged_fifo`

## Requirements
- R1: The line idles high and a character is a low start bit followed by 5, 6, 7 or 8 data bits, least significant bit first. `wlen` selects the count: 0 for 5, 1 for 6, 2 for 7, 3 for 8. The stored data byte is zero above the received bits.
- R2: After the first low sample, every tick up to the middle of the start bit must also read low. A high reading earlier than that returns the receiver to idle, and nothing is stored.
- R3: A bit lasts 16 ticks when `half_ovs` is 0 and 8 ticks when it is 1, and each bit is sampled at its middle.
- R4: With `par_en`=1 a parity bit follows the data and is checked against an expected value, and the parity error flag is set when they differ. With `par_force`=1 the expected value is the inverse of `par_even`. Otherwise the expected value gives even parity (`par_even`=1) or odd parity (`par_even`=0) over the data and parity bits together.
- R5: A stop bit received as 0 sets the framing error flag. One stop bit is checked when `two_stop`=0, and two are checked when it is 1.
- R6: When every sampled bit of a character is 0 (data, parity and stop bits), the break flag is set. The framing error flag is also set and the data byte is 0.
- R7: Entries leave in arrival order. The head outputs show the oldest entry's data byte and its own three flags, and show all zeros when the queue is empty. The flags of a later character never appear before that character reaches the head.
- R8: `fill_level` equals the number of stored entries, from 0 up to DEPTH (default 128). A pop while the queue is empty changes nothing.
- R9: `rx_ready` is 1 exactly when `fill_level` is nonzero and at least `trig_level`.
- R10: A character that completes while the queue holds DEPTH entries is discarded and the stored entries are unchanged. `overrun` goes to 1 and stays there until the next pop that removes an entry.
- R11: After reset the queue is empty, and `fill_level`, `rx_ready`, `overrun` and all head outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_tick | input | 1 | Oversampling tick, one clock wide |
| rxd | input | 1 | Serial receive line (asynchronous) |
| half_ovs | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| wlen | input | 2 | Data bit count minus 5 |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select / inverse of the forced value |
| par_force | input | 1 | Parity forced to a fixed value |
| two_stop | input | 1 | Check two stop bits |
| pop | input | 1 | Remove the head entry |
| trig_level | input | $clog2(DEPTH+1) | Ready threshold |
| head_data | output | 8 | Data byte of the head entry |
| head_perr | output | 1 | Parity error of the head entry |
| head_ferr | output | 1 | Framing error of the head entry |
| head_brk | output | 1 | Break flag of the head entry |
| fill_level | output | $clog2(DEPTH+1) | Number of stored entries |
| rx_ready | output | 1 | Fill level has reached the threshold |
| overrun | output | 1 | A character was dropped while full |

## Verification
The deserializer is driven with characters of 5 and 8 bits at both tick rates, so that a wrong bit count or a wrong mid-bit position shows up as a different stored byte. Parity is exercised in even, odd and forced form, each with a correct and a corrupted bit, which separates the three expected-value rules. Framing errors, an all-zero break and a start glitch that ends before mid-bit each leave a distinct entry, or no entry at all. A three-entry mix with a bad middle character shows whether flags stay attached to their own character. A 130-character burst covers the full boundary, the dropped characters and the drain order.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_PUSH
    } rx_state_e;

    // One queued character with its own error tags (11 bits)
    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       half_ovs,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_force,
    input  logic       two_stop,
    output logic       push,
    output rx_entry_t  entry,
    output rx_state_e  state_o
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] FULL_L = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF_L = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] QTR_L  = CW'(OVS / 4 - 1);

    rx_state_e     state, nxt;
    logic [CW-1:0] cnt, last_cnt, mid_cnt;
    logic [2:0]    bit_idx, last_idx;
    logic [7:0]    shreg;
    logic          stop_idx, samp, any_one, stop_zero, pbit, exp_par, bit_state;

    assign last_cnt  = half_ovs ? HALF_L : FULL_L;
    assign mid_cnt   = half_ovs ? QTR_L  : HALF_L;
    assign last_idx  = 3'd4 + {1'b0, wlen};
    assign bit_state = (state == ST_DATA) || (state == ST_PARITY) || (state == ST_STOP);
    assign samp      = tick && bit_state && (cnt == last_cnt);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && !rxd) nxt = ST_START;
            ST_START: begin
                if (tick) begin
                    if (rxd)                 nxt = ST_IDLE;
                    else if (cnt == mid_cnt) nxt = ST_DATA;
                end
            end
            ST_DATA:   if (samp && (bit_idx == last_idx)) nxt = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (samp) nxt = ST_STOP;
            ST_STOP:   if (samp && (stop_idx == two_stop)) nxt = ST_PUSH;
            ST_PUSH:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Bit timing and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bit_idx   <= '0;
            stop_idx  <= 1'b0;
            shreg     <= '0;
            any_one   <= 1'b0;
            stop_zero <= 1'b0;
            pbit      <= 1'b0;
        end else begin
            if (state != nxt)
                cnt <= '0;
            else if (tick && (state != ST_IDLE) && (state != ST_PUSH))
                cnt <= (cnt == last_cnt) ? '0 : cnt + 1'b1;

            if (state == ST_IDLE) begin
                bit_idx   <= '0;
                stop_idx  <= 1'b0;
                shreg     <= '0;
                any_one   <= 1'b0;
                stop_zero <= 1'b0;
                pbit      <= 1'b0;
            end else if (samp) begin
                any_one <= any_one | rxd;
                if (state == ST_DATA) begin
                    shreg[bit_idx] <= rxd;
                    bit_idx        <= bit_idx + 3'd1;
                end
                if (state == ST_PARITY) pbit <= rxd;
                if (state == ST_STOP) begin
                    if (!rxd) stop_zero <= 1'b1;
                    stop_idx <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        if (par_force)     exp_par = ~par_even;
        else if (par_even) exp_par = ^shreg;
        else               exp_par = ~(^shreg);
        push       = (state == ST_PUSH);
        entry.data = any_one ? shreg : 8'h00;
        entry.perr = par_en && (pbit != exp_par);
        entry.ferr = stop_zero;
        entry.brk  = ~any_one;
        state_o    = state;
    end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rx_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_entry_t     wdata,
    input  logic          pop,
    output rx_entry_t     head,
    output logic [LW-1:0] level,
    output logic          accept,
    output logic          overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic            full, do_pop;

    assign full   = (level == FULL_LVL);
    assign do_pop = pop && (level != '0);
    assign accept = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            unique case ({accept, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push && !accept) overrun <= 1'b1;
            else if (do_pop)     overrun <= 1'b0;
        end
    end

    assign head = (level != '0) ? mem[rd_ptr] : '0;
endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
    import rx_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_tick,
    input  logic             rxd,
    input  logic             half_ovs,
    input  logic [1:0]       wlen,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             par_force,
    input  logic             two_stop,
    input  logic             pop,
    input  logic [LVL_W-1:0] trig_level,
    output logic [7:0]       head_data,
    output logic             head_perr,
    output logic             head_ferr,
    output logic             head_brk,
    output logic [LVL_W-1:0] fill_level,
    output logic             rx_ready,
    output logic             overrun
);
    logic      rx_s, push, accept;
    rx_entry_t frame_entry, head;
    rx_state_e fsm_state;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    rx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (samp_tick),
        .rxd       (rx_s),
        .half_ovs  (half_ovs),
        .wlen      (wlen),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_force (par_force),
        .two_stop  (two_stop),
        .push      (push),
        .entry     (frame_entry),
        .state_o   (fsm_state)
    );

    rx_tag_fifo #(.DEPTH(DEPTH), .LW(LVL_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wdata   (frame_entry),
        .pop     (pop),
        .head    (head),
        .level   (fill_level),
        .accept  (accept),
        .overrun (overrun)
    );

    assign head_data = head.data;
    assign head_perr = head.perr;
    assign head_ferr = head.ferr;
    assign head_brk  = head.brk;
    assign rx_ready  = (fill_level != '0) && (fill_level >= trig_level);
endmodule

// File: rtl/rx_tagged_fifo_chk.sv
module rx_tagged_fifo_chk
    import rx_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_tick,
    input logic             rx_s,
    input rx_state_e        state,
    input logic             push,
    input logic             pop,
    input logic [LVL_W-1:0] fill_level,
    input logic [7:0]       head_data,
    input logic             head_perr,
    input logic             head_ferr,
    input logic             head_brk,
    input logic             rx_ready,
    input logic             overrun
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    // R2: a high line before mid start bit returns to idle
    p_glitch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && samp_tick && rx_s) |=> (state == ST_IDLE));

    // R1: one write per completed character
    p_single_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // R7: head holds while nothing is removed
    p_head_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level != '0 && !pop) |=>
        ($stable(head_data) && $stable(head_perr) && $stable(head_ferr) && $stable(head_brk)));

    // R8: never above depth
    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL_LVL);

    // R8: pop on empty has no effect
    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && fill_level == '0 && !push) |=> (fill_level == '0));

    // R9: no ready indication while empty
    p_ready_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> !rx_ready);

    // R10: overrun only rises from a full queue
    p_ovr_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(fill_level) == FULL_LVL));

    // R10: a write into a full queue is dropped
    p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fill_level == FULL_LVL && !pop) |=> (fill_level == FULL_LVL && overrun));
endmodule

bind rx_tagged_fifo rx_tagged_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_tick  (samp_tick),
    .rx_s       (rx_s),
    .state      (fsm_state),
    .push       (push),
    .pop        (pop),
    .fill_level (fill_level),
    .head_data  (head_data),
    .head_perr  (head_perr),
    .head_ferr  (head_ferr),
    .head_brk   (head_brk),
    .rx_ready   (rx_ready),
    .overrun    (overrun)
);

// File: tb/sim_rx_tagged_fifo.sv
module sim_rx_tagged_fifo;
    localparam int DEPTH = 128;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          samp_tick = 1'b0;
    logic          rxd = 1'b1;
    logic          half_ovs = 1'b0;
    logic [1:0]    wlen = 2'd3;
    logic          par_en = 1'b0, par_even = 1'b0, par_force = 1'b0, two_stop = 1'b0;
    logic          pop = 1'b0;
    logic [LW-1:0] trig_level = LW'(1);
    logic [7:0]    head_data;
    logic          head_perr, head_ferr, head_brk, rx_ready, overrun;
    logic [LW-1:0] fill_level;

    int            checks = 0, fails = 0;
    bit            cmp_on = 1'b0, done = 1'b0;
    logic [10:0]   q[$];
    bit            m_ovr = 1'b0;

    always #4 clk = ~clk;

    rx_tagged_fifo u0 (
        .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rxd(rxd),
        .half_ovs(half_ovs), .wlen(wlen), .par_en(par_en), .par_even(par_even),
        .par_force(par_force), .two_stop(two_stop), .pop(pop), .trig_level(trig_level),
        .head_data(head_data), .head_perr(head_perr), .head_ferr(head_ferr),
        .head_brk(head_brk), .fill_level(fill_level), .rx_ready(rx_ready), .overrun(overrun)
    );

    initial forever begin
        @(negedge clk);
        samp_tick = ~samp_tick;
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [10:0] head_now();
        return {head_brk, head_ferr, head_perr, head_data};
    endfunction

    // Reference comparison on every clock while no character is in flight
    always @(negedge clk) begin : cmp_blk
        logic [10:0] eh;
        if (cmp_on && !done) begin
            eh = (q.size() != 0) ? q[0] : 11'h0;
            chk(head_now() == eh, "R7", "head entry", int'(head_now()), int'(eh));
            chk(int'(fill_level) == q.size(), "R8", "fill level", int'(fill_level), q.size());
            chk(rx_ready == (q.size() != 0 && q.size() >= int'(trig_level)), "R9", "ready",
                int'(rx_ready), int'(q.size() != 0 && q.size() >= int'(trig_level)));
            chk(overrun == m_ovr, "R10", "overrun", int'(overrun), int'(m_ovr));
        end
    end

    task automatic send_bit(input bit b);
        int ov;
        ov = half_ovs ? 8 : 16;
        rxd = b;
        repeat (2 * ov) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit brk_f);
        int nb;
        logic [7:0] sent;
        bit pe, pb, any1, sz, perr, b;
        nb = 5 + int'(wlen);
        sent = 8'h00;
        for (int i = 0; i < nb; i++) sent[i] = brk_f ? 1'b0 : d[i];
        any1 = 0; sz = 0; perr = 0;
        cmp_on = 0;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            any1 |= sent[i];
            send_bit(sent[i]);
        end
        if (par_en) begin
            pe = par_force ? !par_even : (par_even ? ^sent : !(^sent));
            pb = brk_f ? 1'b0 : (pe ^ bad_par);
            perr = (pb != pe);
            any1 |= pb;
            send_bit(pb);
        end
        for (int s = 0; s < (two_stop ? 2 : 1); s++) begin
            b = brk_f ? 1'b0 : ((s == 0 && bad_stop) ? 1'b0 : 1'b1);
            if (!b) sz = 1;
            any1 |= b;
            send_bit(b);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        if (q.size() < DEPTH) q.push_back({!any1, sz, perr, sent});
        else m_ovr = 1'b1;
        cmp_on = 1;
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop = 1'b1;
        @(posedge clk);
        #1;
        if (q.size() != 0) begin
            void'(q.pop_front());
            m_ovr = 1'b0;
        end
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic head_is(input string tag, input logic [10:0] exp);
        @(negedge clk);
        chk(head_now() == exp, tag, "head entry", int'(head_now()), int'(exp));
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11: state during and right after reset
        chk(fill_level == '0, "R11", "level in reset", int'(fill_level), 0);
        chk(!rx_ready && !overrun, "R11", "flags in reset", int'({rx_ready, overrun}), 0);
        chk(head_now() == 11'h0, "R11", "head in reset", int'(head_now()), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        cmp_on = 1;

        // R1: 8 data bits, then 5 data bits with upper bits cleared
        send_frame(8'hA5, 0, 0, 0);
        head_is("R1", 11'h0A5);
        do_pop();
        wlen = 2'd0;
        send_frame(8'hFF, 0, 0, 0);
        head_is("R1", 11'h01F);
        do_pop();
        wlen = 2'd3;

        // R3: 8 ticks per bit
        half_ovs = 1'b1;
        send_frame(8'h3C, 0, 0, 0);
        head_is("R3", 11'h03C);
        do_pop();
        half_ovs = 1'b0;

        // R4: even, odd and forced parity, good and corrupted
        par_en = 1'b1; par_even = 1'b1;
        send_frame(8'h07, 0, 0, 0); head_is("R4", 11'h007); do_pop();
        send_frame(8'h07, 1, 0, 0); head_is("R4", 11'h107); do_pop();
        par_even = 1'b0;
        send_frame(8'h81, 0, 0, 0); head_is("R4", 11'h081); do_pop();
        send_frame(8'h81, 1, 0, 0); head_is("R4", 11'h181); do_pop();
        par_force = 1'b1; par_even = 1'b1;
        send_frame(8'h5A, 0, 0, 0); head_is("R4", 11'h05A); do_pop();
        send_frame(8'h5A, 1, 0, 0); head_is("R4", 11'h15A); do_pop();
        par_force = 1'b0; par_en = 1'b0;

        // R5: framing errors with one and two stop bits
        send_frame(8'h66, 0, 1, 0); head_is("R5", 11'h266); do_pop();
        two_stop = 1'b1;
        send_frame(8'h99, 0, 0, 0); head_is("R5", 11'h099); do_pop();
        send_frame(8'h99, 0, 1, 0); head_is("R5", 11'h299); do_pop();
        two_stop = 1'b0;

        // R6: all-zero character
        send_frame(8'h00, 0, 0, 1); head_is("R6", 11'h600); do_pop();

        // R2: start glitch shorter than half a bit
        cmp_on = 0;
        rxd = 1'b0;
        repeat (10) @(negedge clk);
        rxd = 1'b1;
        repeat (100) @(negedge clk);
        cmp_on = 1;
        @(negedge clk);
        chk(fill_level == '0, "R2", "level after glitch", int'(fill_level), 0);

        // R7: tags stay with their own character
        send_frame(8'h11, 0, 0, 0);
        send_frame(8'h22, 0, 1, 0);
        send_frame(8'h33, 0, 0, 0);
        head_is("R7", 11'h011); do_pop();
        head_is("R7", 11'h222); do_pop();
        head_is("R7", 11'h033); do_pop();

        // R8: pop while empty
        do_pop();
        @(negedge clk);
        chk(fill_level == '0, "R8", "level after empty pop", int'(fill_level), 0);

        // R9: threshold comparison
        trig_level = LW'(3);
        send_frame(8'h01, 0, 0, 0);
        send_frame(8'h02, 0, 0, 0);
        @(negedge clk);
        chk(!rx_ready, "R9", "ready below threshold", int'(rx_ready), 0);
        send_frame(8'h03, 0, 0, 0);
        @(negedge clk);
        chk(rx_ready, "R9", "ready at threshold", int'(rx_ready), 1);
        trig_level = LW'(0);
        @(negedge clk);
        chk(rx_ready, "R9", "ready with zero threshold", int'(rx_ready), 1);
        repeat (3) do_pop();
        @(negedge clk);
        chk(!rx_ready, "R9", "ready when empty", int'(rx_ready), 0);
        trig_level = LW'(1);

        // R10: fill to depth, overflow, then drain in order
        half_ovs = 1'b1;
        for (int i = 0; i < DEPTH; i++) send_frame(8'(i), 0, 0, 0);
        @(negedge clk);
        chk(int'(fill_level) == DEPTH, "R8", "level when full", int'(fill_level), DEPTH);
        send_frame(8'hEE, 0, 0, 0);
        send_frame(8'hEF, 0, 0, 0);
        @(negedge clk);
        chk(overrun, "R10", "overrun set", int'(overrun), 1);
        chk(int'(fill_level) == DEPTH, "R10", "level after drop", int'(fill_level), DEPTH);
        chk(head_now() == 11'h000, "R10", "head after drop", int'(head_now()), 0);
        do_pop();
        chk(!overrun, "R10", "overrun cleared by pop", int'(overrun), 0);
        chk(int'(fill_level) == DEPTH - 1, "R10", "level after pop", int'(fill_level), DEPTH - 1);
        for (int i = 1; i < DEPTH; i++) begin
            chk(head_data == 8'(i), "R7", "drain order", int'(head_data), i);
            do_pop();
        end
        @(negedge clk);
        chk(fill_level == '0, "R8", "level after drain", int'(fill_level), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule